// File: doc/BRIEF.md
# Register Alias Rename Table

The block keeps, for every architectural register of a four-wide out-of-order core, one mapping entry. An entry is either "ready", meaning the current value sits in the register file, or "busy" with a 3-bit producer tag naming the functional unit that will deliver the value. Each cycle a group of up to four instructions is renamed together. Each instruction's two sources are resolved to ready or busy-with-tag for the instruction window. Each valid destination is remapped to the fresh producer tag that the allocator supplies with the slot. Because every new destination gets a fresh tag, write-after-read and write-after-write hazards between instructions disappear.

Program order inside a group is slot order, slot 0 first. A later slot's source resolves to the tag of the latest earlier slot in the same group that writes that register. When several slots write the same register, the highest slot sets the table entry. A result broadcast with tag T returns every entry still mapped to T to ready. Entries already remapped to another tag keep their mapping. Register 0 is never renamed. A flush returns the whole table to ready in one cycle.

Top module: `rat_rename`

## Requirements
- R1: After reset every register reads as ready. A ready source drives busy 0 and tag 0.
- R2: A source whose register was renamed in an earlier cycle, and not cleared since, drives busy 1 and the tag of its most recent mapping.
- R3: A source of slot k resolves to busy with the tag of the highest slot j < k in the same group that has valid 1, write 1 and a destination equal to that source. This overrides the table and any broadcast.
- R4: A slot's own destination, and the destinations of higher slots, do not affect that slot's sources.
- R5: When several valid slots write the same register, the next cycle shows the tag of the highest such slot.
- R6: A broadcast with tag T returns to ready every entry mapped to T in the next cycle. Entries mapped to another tag stay busy with their tag.
- R7: A rename of a register in the same cycle as a broadcast of the tag it held leaves it busy with the new tag.
- R8: A source whose table entry maps to the tag broadcast in the same cycle, and that no earlier slot writes, resolves as ready in that cycle.
- R9: Register 0 always resolves as ready, and writes to register 0 leave it ready.
- R10: A flush makes every register ready in the next cycle, and this takes priority over any rename in that same cycle.
- R11: A slot with valid 0, or with write 0, changes no entry and bypasses to no later slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Return all entries to ready |
| ren_valid_i | input | 4 | Slot holds an instruction |
| ren_wr_i | input | 4 | Slot writes a destination |
| ren_dst_i | input | 4x5 | Destination register per slot |
| ren_tag_i | input | 4x3 | Fresh producer tag per slot |
| ren_src1_i | input | 4x5 | First source register per slot |
| ren_src2_i | input | 4x5 | Second source register per slot |
| bc_valid_i | input | 1 | Result broadcast this cycle |
| bc_tag_i | input | 3 | Tag of the broadcast result |
| src1_busy_o | output | 4 | First source not yet produced |
| src1_tag_o | output | 4x3 | Producer tag of first source, 0 when ready |
| src2_busy_o | output | 4 | Second source not yet produced |
| src2_tag_o | output | 4x3 | Producer tag of second source, 0 when ready |

## Verification
The functions that overlap in a cycle are renaming a group and a result broadcast. A source can read an entry whose tag is broadcasting, and a slot can remap a register whose old tag is broadcasting. Directed cases place the broadcast tag on a mapped register while one slot reads it and a later slot rewrites it, so both resolution order and table update order are tested. Random groups over a small register range add broadcast tags taken from live mappings. A reference table in the bench is then compared with every source output and with full table read-outs.

// File: rtl/rat_pkg.sv
package rat_pkg;
  parameter int unsigned DEF_NUM_ARCH = 32;
  parameter int unsigned DEF_TAG_W    = 3;
  parameter int unsigned DEF_GROUP    = 4;
endpackage

// File: rtl/rat_lookup.sv
module rat_lookup #(
  parameter int unsigned NUM_ARCH = rat_pkg::DEF_NUM_ARCH,
  parameter int unsigned TAG_W    = rat_pkg::DEF_TAG_W,
  parameter int unsigned GROUP    = rat_pkg::DEF_GROUP,
  parameter int unsigned SLOT     = 0,
  localparam int unsigned AREG_W  = $clog2(NUM_ARCH)
) (
  input  logic [NUM_ARCH-1:0]            tbl_busy_i,
  input  logic [NUM_ARCH-1:0][TAG_W-1:0] tbl_tag_i,
  input  logic [AREG_W-1:0]              src_i,
  input  logic [GROUP-1:0]               wr_en_i,
  input  logic [GROUP-1:0][AREG_W-1:0]   dst_i,
  input  logic [GROUP-1:0][TAG_W-1:0]    tag_i,
  input  logic                           bc_valid_i,
  input  logic [TAG_W-1:0]               bc_tag_i,
  output logic                           busy_o,
  output logic [TAG_W-1:0]               tag_o
);
  logic             busy_q;
  logic [TAG_W-1:0] tag_q;

  always_comb begin
    busy_q = tbl_busy_i[src_i] && !(bc_valid_i && tbl_tag_i[src_i] == bc_tag_i);
    tag_q  = tbl_tag_i[src_i];
    // only strictly earlier slots; last earlier writer wins
    for (int j = 0; j < int'(SLOT); j++) begin
      if (wr_en_i[j] && dst_i[j] == src_i) begin
        busy_q = 1'b1;
        tag_q  = tag_i[j];
      end
    end
    if (src_i == '0) busy_q = 1'b0;
    busy_o = busy_q;
    tag_o  = busy_q ? tag_q : '0;
  end
endmodule

// File: rtl/rat_table.sv
module rat_table #(
  parameter int unsigned NUM_ARCH = rat_pkg::DEF_NUM_ARCH,
  parameter int unsigned TAG_W    = rat_pkg::DEF_TAG_W,
  parameter int unsigned GROUP    = rat_pkg::DEF_GROUP,
  localparam int unsigned AREG_W  = $clog2(NUM_ARCH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic [GROUP-1:0]               wr_en_i,
  input  logic [GROUP-1:0][AREG_W-1:0]   dst_i,
  input  logic [GROUP-1:0][TAG_W-1:0]    tag_i,
  input  logic                           bc_valid_i,
  input  logic [TAG_W-1:0]               bc_tag_i,
  output logic [NUM_ARCH-1:0]            busy_o,
  output logic [NUM_ARCH-1:0][TAG_W-1:0] tag_o
);
  logic [NUM_ARCH-1:0]            busy_d;
  logic [NUM_ARCH-1:0][TAG_W-1:0] tag_d;

  always_comb begin
    busy_d = busy_o;
    tag_d  = tag_o;
    for (int r = 0; r < int'(NUM_ARCH); r++) begin
      if (bc_valid_i && busy_o[r] && tag_o[r] == bc_tag_i) busy_d[r] = 1'b0;
    end
    // slot order: later writers overwrite earlier ones
    for (int k = 0; k < int'(GROUP); k++) begin
      if (wr_en_i[k] && dst_i[k] != '0) begin
        busy_d[dst_i[k]] = 1'b1;
        tag_d[dst_i[k]]  = tag_i[k];
      end
    end
    if (flush_i) busy_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= '0;
      tag_o  <= '0;
    end else begin
      busy_o <= busy_d;
      tag_o  <= tag_d;
    end
  end

  a_r10_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> busy_o == '0);

  a_r5_last_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i[GROUP-1] && dst_i[GROUP-1] != '0 && !flush_i) |=>
      (busy_o[$past(dst_i[GROUP-1])] && tag_o[$past(dst_i[GROUP-1])] == $past(tag_i[GROUP-1])));

  for (genvar r = 1; r < int'(NUM_ARCH); r++) begin : g_chk
    a_r6_bc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bc_valid_i && !flush_i && wr_en_i == '0 && busy_o[r] && tag_o[r] == bc_tag_i) |=> !busy_o[r]);
  end
endmodule

// File: rtl/rat_rename.sv
module rat_rename #(
  parameter int unsigned NUM_ARCH = rat_pkg::DEF_NUM_ARCH,
  parameter int unsigned TAG_W    = rat_pkg::DEF_TAG_W,
  parameter int unsigned GROUP    = rat_pkg::DEF_GROUP,
  localparam int unsigned AREG_W  = $clog2(NUM_ARCH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic [GROUP-1:0]             ren_valid_i,
  input  logic [GROUP-1:0]             ren_wr_i,
  input  logic [GROUP-1:0][AREG_W-1:0] ren_dst_i,
  input  logic [GROUP-1:0][TAG_W-1:0]  ren_tag_i,
  input  logic [GROUP-1:0][AREG_W-1:0] ren_src1_i,
  input  logic [GROUP-1:0][AREG_W-1:0] ren_src2_i,
  input  logic                         bc_valid_i,
  input  logic [TAG_W-1:0]             bc_tag_i,
  output logic [GROUP-1:0]             src1_busy_o,
  output logic [GROUP-1:0][TAG_W-1:0]  src1_tag_o,
  output logic [GROUP-1:0]             src2_busy_o,
  output logic [GROUP-1:0][TAG_W-1:0]  src2_tag_o
);
  logic [NUM_ARCH-1:0]            tbl_busy;
  logic [NUM_ARCH-1:0][TAG_W-1:0] tbl_tag;
  logic [GROUP-1:0]               wr_en;

  always_comb begin
    for (int k = 0; k < int'(GROUP); k++)
      wr_en[k] = ren_valid_i[k] && ren_wr_i[k] && ren_dst_i[k] != '0;
  end

  rat_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .GROUP(GROUP)) u_table (
    .clk_i, .rst_ni, .flush_i,
    .wr_en_i(wr_en), .dst_i(ren_dst_i), .tag_i(ren_tag_i),
    .bc_valid_i, .bc_tag_i,
    .busy_o(tbl_busy), .tag_o(tbl_tag)
  );

  for (genvar k = 0; k < int'(GROUP); k++) begin : g_slot
    rat_lookup #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .GROUP(GROUP), .SLOT(k)) u_src1 (
      .tbl_busy_i(tbl_busy), .tbl_tag_i(tbl_tag), .src_i(ren_src1_i[k]),
      .wr_en_i(wr_en), .dst_i(ren_dst_i), .tag_i(ren_tag_i),
      .bc_valid_i, .bc_tag_i,
      .busy_o(src1_busy_o[k]), .tag_o(src1_tag_o[k])
    );
    rat_lookup #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .GROUP(GROUP), .SLOT(k)) u_src2 (
      .tbl_busy_i(tbl_busy), .tbl_tag_i(tbl_tag), .src_i(ren_src2_i[k]),
      .wr_en_i(wr_en), .dst_i(ren_dst_i), .tag_i(ren_tag_i),
      .bc_valid_i, .bc_tag_i,
      .busy_o(src2_busy_o[k]), .tag_o(src2_tag_o[k])
    );

    a_r9_zero_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ren_src1_i[k] == '0) |-> !src1_busy_o[k]);

    if (k > 0) begin : g_byp
      a_r3_prev_slot_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en[k-1] && ren_dst_i[k-1] == ren_src2_i[k]) |->
          (src2_busy_o[k] && src2_tag_o[k] == ren_tag_i[k-1]));
    end
  end
endmodule

// File: tb/rat_rename_test.sv
module rat_rename_test;
  localparam int NA = 32;
  localparam int TW = 3;
  localparam int G  = 4;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush;
  logic [G-1:0] vld, wr;
  logic [G-1:0][AW-1:0] dst, s1, s2;
  logic [G-1:0][TW-1:0] tg;
  logic bcv;
  logic [TW-1:0] bct;
  logic [G-1:0] b1, b2;
  logic [G-1:0][TW-1:0] t1, t2;

  int checks = 0;
  int fails = 0;
  bit m_busy [NA];
  int m_tag  [NA];

  always #5 clk = ~clk;

  rat_rename uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .ren_valid_i(vld), .ren_wr_i(wr), .ren_dst_i(dst), .ren_tag_i(tg),
    .ren_src1_i(s1), .ren_src2_i(s2), .bc_valid_i(bcv), .bc_tag_i(bct),
    .src1_busy_o(b1), .src1_tag_o(t1), .src2_busy_o(b2), .src2_tag_o(t2)
  );

  task automatic clear_in();
    flush = 0; vld = '0; wr = '0; dst = '0; s1 = '0; s2 = '0; tg = '0; bcv = 0; bct = '0;
  endtask

  function automatic void ref_src(input int k, input int s, output bit b, output int t,
                                  output string req);
    b = m_busy[s] && !(bcv && m_tag[s] == int'(bct));
    t = b ? m_tag[s] : 0;
    req = (m_busy[s] && !b) ? "R8" : "R2";
    if (wr[k] && vld[k] && int'(dst[k]) == s) req = "R4";
    for (int j = 0; j < k; j++)
      if (vld[j] && wr[j] && int'(dst[j]) == s && s != 0) begin
        b = 1; t = int'(tg[j]); req = "R3";
      end
    for (int j = 0; j < k; j++)
      if (!(vld[j] && wr[j]) && int'(dst[j]) == s && s != 0 && req != "R3") req = "R11";
    if (s == 0) begin b = 0; t = 0; req = "R9"; end
  endfunction

  task automatic cmp(input string req, input int k, input int n, input bit ab, input int at,
                     input bit eb, input int et);
    checks++;
    if (ab !== eb || at != et) begin
      fails++;
      $display("FAIL %s slot%0d src%0d busy=%0d tag=%0d expected busy=%0d tag=%0d",
               req, k, n, ab, at, eb, et);
    end
  endtask

  task automatic check_all(input string force_req);
    bit eb; int et; string rq;
    #1;
    for (int k = 0; k < G; k++) begin
      ref_src(k, int'(s1[k]), eb, et, rq);
      cmp(force_req == "" ? rq : force_req, k, 1, b1[k], int'(t1[k]), eb, et);
      ref_src(k, int'(s2[k]), eb, et, rq);
      cmp(force_req == "" ? rq : force_req, k, 2, b2[k], int'(t2[k]), eb, et);
    end
  endtask

  // table read-out through the source ports, no renames active
  task automatic read_all(input string req);
    clear_in();
    for (int base = 0; base < NA; base += 8) begin
      for (int k = 0; k < G; k++) begin
        s1[k] = AW'(base + k);
        s2[k] = AW'(base + 4 + k);
      end
      check_all(req);
    end
    clear_in();
  endtask

  task automatic step();
    bit nb [NA]; int nt [NA];
    check_all("");
    for (int r = 0; r < NA; r++) begin
      nb[r] = m_busy[r]; nt[r] = m_tag[r];
      if (bcv && m_busy[r] && m_tag[r] == int'(bct)) nb[r] = 0;
    end
    for (int k = 0; k < G; k++)
      if (vld[k] && wr[k] && dst[k] != 0) begin nb[dst[k]] = 1; nt[dst[k]] = int'(tg[k]); end
    if (flush) for (int r = 0; r < NA; r++) nb[r] = 0;
    @(posedge clk);
    for (int r = 0; r < NA; r++) begin m_busy[r] = nb[r]; m_tag[r] = nt[r]; end
    @(negedge clk);
  endtask

  task automatic slot(input int k, input int d, input int t, input int a, input int b);
    vld[k] = 1; wr[k] = 1; dst[k] = AW'(d); tg[k] = TW'(t); s1[k] = AW'(a); s2[k] = AW'(b);
  endtask

  bit done = 0;
  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    clear_in();
    for (int r = 0; r < NA; r++) begin m_busy[r] = 0; m_tag[r] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_all("R1");

    // R3 R4: intra-group chain on r5
    clear_in();
    slot(0, 5, 1, 5, 5);
    slot(1, 6, 7, 5, 0); wr[1] = 0;
    slot(2, 5, 2, 5, 1);
    slot(3, 9, 6, 5, 5);
    step();
    read_all("R5");

    // R6: broadcast tag with no mapping leaves r5; then two regs on tag 3 cleared
    clear_in(); bcv = 1; bct = 3'd1; step();
    read_all("R6");
    clear_in(); slot(0, 7, 3, 0, 0); slot(1, 8, 3, 7, 8); step();
    clear_in(); bcv = 1; bct = 3'd3; s1[0] = 5'd7; s2[0] = 5'd8; step();
    read_all("R6");

    // R7 R8: rename and broadcast in one cycle
    clear_in(); slot(0, 9, 4, 0, 0); wr[1] = 0; step();
    clear_in(); bcv = 1; bct = 3'd4;
    slot(0, 11, 0, 9, 0); wr[0] = 0;
    slot(1, 9, 5, 9, 9);
    slot(2, 12, 6, 9, 0);
    step();
    read_all("R7");

    // R9: writes to register 0
    clear_in(); slot(0, 0, 2, 0, 0); slot(1, 0, 3, 0, 0); step();
    read_all("R9");

    // R11: invalid slot and non-writing slot
    clear_in(); slot(0, 10, 2, 0, 0); vld[0] = 0; slot(1, 13, 3, 0, 0); wr[1] = 0;
    s1[2] = 5'd10; s2[3] = 5'd13; vld[2] = 1; vld[3] = 1; step();
    read_all("R11");

    // R10: flush with a rename in the same cycle
    clear_in(); slot(0, 14, 1, 0, 0); slot(1, 15, 2, 0, 0); step();
    clear_in(); flush = 1; slot(0, 16, 4, 0, 0); slot(3, 17, 5, 0, 0); step();
    read_all("R10");

    // random groups
    for (int n = 0; n < 3000; n++) begin
      int rng;
      clear_in();
      rng = ($urandom % 2) ? 8 : NA;
      for (int k = 0; k < G; k++) begin
        vld[k] = ($urandom % 4) != 0;
        wr[k]  = ($urandom % 4) != 0;
        dst[k] = AW'($urandom % rng);
        tg[k]  = TW'($urandom % 8);
        s1[k]  = AW'($urandom % rng);
        s2[k]  = AW'($urandom % rng);
      end
      bcv = ($urandom % 2) != 0;
      bct = TW'(m_tag[$urandom % 8]);
      flush = ($urandom % 40) == 0;
      step();
      if (n % 500 == 0) read_all("R2");
    end
    read_all("R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule